// File: doc/BRIEF.md
# Tearing effect sync detector

This block watches one tearing-effect line from a display panel and raises a one-cycle match pulse at the moment a pending frame write may begin. The panel sends horizontal and vertical sync on the same wire. The block tells them apart by how long each pulse stays at its active level, measured in ticks of a divided clock. A pulse at least as long as the vertical threshold is vertical sync. A pulse at least as long as the horizontal threshold, but shorter than the vertical one, is horizontal sync. Shorter pulses are discarded as glitches. The active level of each pulse type can be inverted on its own.

After a vertical sync, the block counts horizontal syncs as lines. In the line-match mode, the pulse fires once per frame when the line count reaches a programmed target. In the vertical-only mode, it fires on every vertical sync. Software writes two configuration words through a write-only register port, and a separate enable input gates the whole match logic.

Top module: `te_sync_detector`

## Requirements
- R1: After reset `match_o` is low, the line count is zero, and no frame is considered started.
- R2: A pulse whose active-level width is at least the vertical threshold is a vertical sync. In mode 3 (control word bits [27:26] = 2'b11), every vertical sync produces a match.
- R3: A pulse whose width is at least the horizontal threshold and below the vertical threshold is a horizontal sync. Narrower pulses are ignored and do not advance the line count.
- R4: Widths are counted in ticks of (div+1) clock cycles, where div is timing word bits [14:12]. The horizontal threshold is timing word bits [11:0].
- R5: The horizontal active level is high unless control word bit 12 is set, and the vertical active level is high unless control word bit 13 is set. The vertical threshold is control word bits [11:0].
- R6: In mode 2 (bits [27:26] = 2'b10), a vertical sync resets the line count to 0 and each horizontal sync adds one. A match fires when the count reached by a sync event equals the target line (control word bits [25:15]), so a target of 0 matches on the vertical sync itself.
- R7: In mode 2, at most one match occurs per frame, and a target beyond the number of lines in the frame produces none.
- R8: Horizontal syncs that arrive before the first vertical sync after enabling are not counted and cause no match.
- R9: While `det_en` is low, no match is produced, and the frame and line state are cleared.
- R10: A match lasts exactly one cycle. It rises SYNC_STAGES+1 clock edges after the edge that ends the triggering pulse.
- R11: Modes 0 and 1 never produce a match.
- R12: The width counter saturates at 4095, so a vertical threshold of 4095 is reachable with an arbitrarily long pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_en | input | 1 | Enables match generation |
| te_in | input | 1 | Tearing-effect pin from the panel (asynchronous) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control word, 1 selects the timing word |
| cfg_wdata | input | 32 | Configuration write data |
| match_o | output | 1 | One-cycle match pulse |

## Verification
The bench drives `te_in` on falling clock edges and logs the cycle in which each pulse's trailing edge was driven. The two-stage synchronizer, the edge compare and the match register put the match pulse three rising edges later. The bench therefore expects a match in exactly that cycle, counted from the trailing edge of the vertical sync or of the target horizontal sync. Match counts per frame are compared after a quiet gap longer than this latency, so a late pulse cannot leak into the next frame. Pulse widths sit at least two ticks away from either threshold, which keeps the result independent of the divider's phase.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;
    localparam int THR_W  = 12;
    localparam int LINE_W = 11;
    localparam int DIV_W  = 3;

    typedef enum logic [1:0] {
        MODE_NONE0 = 2'd0,
        MODE_NONE1 = 2'd1,
        MODE_LINE  = 2'd2,
        MODE_VSYNC = 2'd3
    } te_mode_e;

    typedef struct packed {
        logic [THR_W-1:0]  vs_thr;
        logic              hs_inv;
        logic              vs_inv;
        logic [LINE_W-1:0] target;
        te_mode_e          mode;
        logic [THR_W-1:0]  hs_thr;
        logic [DIV_W-1:0]  div_m1;
    } te_cfg_t;
endpackage

// File: rtl/te_pulse_classifier.sv
module te_pulse_classifier #(
    parameter int SYNC_STAGES = 2,
    parameter int THR_W       = 12,
    parameter int DIV_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             te_i,
    input  logic [THR_W-1:0] hs_thr_i,
    input  logic [THR_W-1:0] vs_thr_i,
    input  logic [DIV_W-1:0] div_m1_i,
    input  logic             hs_inv_i,
    input  logic             vs_inv_i,
    output logic             hs_evt_o,
    output logic             vs_evt_o
);
    localparam logic [THR_W-1:0] WIDTH_MAX = {THR_W{1'b1}};

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [DIV_W-1:0]       presc;
        logic [THR_W-1:0]       width;
    } cls_state_t;

    cls_state_t q, d;
    logic lvl, edge_seen, hs_lvl_ok, vs_lvl_ok;

    always_comb begin
        d         = q;
        d.sync    = {q.sync[SYNC_STAGES-2:0], te_i};
        lvl       = q.sync[SYNC_STAGES-1];
        d.prev    = lvl;
        edge_seen = (lvl != q.prev);

        if (edge_seen) begin
            d.presc = '0;
            d.width = '0;
        end else if (q.presc == div_m1_i) begin
            d.presc = '0;
            if (q.width != WIDTH_MAX) begin
                d.width = q.width + 1'b1;
            end
        end else begin
            d.presc = q.presc + 1'b1;
        end

        // the run that just ended had level q.prev and length q.width
        hs_lvl_ok = (q.prev == ~hs_inv_i);
        vs_lvl_ok = (q.prev == ~vs_inv_i);
        vs_evt_o  = edge_seen && vs_lvl_ok && (q.width >= vs_thr_i);
        hs_evt_o  = edge_seen && hs_lvl_ok && (q.width >= hs_thr_i)
                    && (q.width < vs_thr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/te_line_matcher.sv
module te_line_matcher
    import te_sync_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              hs_evt_i,
    input  logic              vs_evt_i,
    input  te_mode_e          mode_i,
    input  logic [LINE_W-1:0] target_i,
    output logic              match_o,
    output logic [LINE_W-1:0] line_o
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              framed;
        logic              fired;
        logic              match;
    } mat_state_t;

    mat_state_t q, d;
    logic [LINE_W-1:0] line_inc;

    always_comb begin
        d        = q;
        d.match  = 1'b0;
        line_inc = (q.line == LINE_MAX) ? q.line : q.line + 1'b1;

        if (!en_i) begin
            d.line   = '0;
            d.framed = 1'b0;
            d.fired  = 1'b0;
        end else if (vs_evt_i) begin
            d.line   = '0;
            d.framed = 1'b1;
            d.fired  = 1'b0;
            if (mode_i == MODE_VSYNC) begin
                d.match = 1'b1;
            end else if (mode_i == MODE_LINE && target_i == '0) begin
                d.match = 1'b1;
                d.fired = 1'b1;
            end
        end else if (hs_evt_i && q.framed) begin
            d.line = line_inc;
            if (mode_i == MODE_LINE && !q.fired && line_inc == target_i) begin
                d.match = 1'b1;
                d.fired = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign match_o = q.match;
    assign line_o  = q.line;
endmodule

// File: rtl/te_sync_detector.sv
module te_sync_detector
    import te_sync_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_en,
    input  logic             te_in,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic             match_o
);
    localparam int HS_INV_BIT = 12;
    localparam int VS_INV_BIT = 13;
    localparam int LINE_LSB   = 15;
    localparam int MODE_LSB   = 26;
    localparam int DIV_LSB    = 12;

    te_cfg_t           cfg_q, cfg_d;
    logic              hs_evt, vs_evt;
    logic [LINE_W-1:0] line_cnt;
    logic [1:0]        cfg_mode;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (!cfg_sel) begin
                cfg_d.vs_thr = cfg_wdata[THR_W-1:0];
                cfg_d.hs_inv = cfg_wdata[HS_INV_BIT];
                cfg_d.vs_inv = cfg_wdata[VS_INV_BIT];
                cfg_d.target = cfg_wdata[LINE_LSB +: LINE_W];
                cfg_d.mode   = te_mode_e'(cfg_wdata[MODE_LSB +: 2]);
            end else begin
                cfg_d.hs_thr = cfg_wdata[THR_W-1:0];
                cfg_d.div_m1 = cfg_wdata[DIV_LSB +: DIV_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_mode = cfg_q.mode;

    te_pulse_classifier #(
        .SYNC_STAGES(SYNC_STAGES),
        .THR_W      (THR_W),
        .DIV_W      (DIV_W)
    ) cls_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .te_i    (te_in),
        .hs_thr_i(cfg_q.hs_thr),
        .vs_thr_i(cfg_q.vs_thr),
        .div_m1_i(cfg_q.div_m1),
        .hs_inv_i(cfg_q.hs_inv),
        .vs_inv_i(cfg_q.vs_inv),
        .hs_evt_o(hs_evt),
        .vs_evt_o(vs_evt)
    );

    te_line_matcher #(
        .LINE_W(LINE_W)
    ) mat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (det_en),
        .hs_evt_i(hs_evt),
        .vs_evt_i(vs_evt),
        .mode_i  (cfg_q.mode),
        .target_i(cfg_q.target),
        .match_o (match_o),
        .line_o  (line_cnt)
    );
endmodule

// File: rtl/te_sync_checker.sv
module te_sync_checker #(
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              det_en,
    input logic              hs_evt,
    input logic              vs_evt,
    input logic [1:0]        mode,
    input logic [LINE_W-1:0] line,
    input logic              match_o
);
    assert_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

    assert_types_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hs_evt, vs_evt}));

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> !match_o);

    assert_match_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(hs_evt || vs_evt));

    assert_vsync_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && $past(mode) == 2'd3) |-> $past(vs_evt));

    assert_line_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en && vs_evt) |=> (line == '0));

    assert_off_modes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(mode[1]));
endmodule

bind te_sync_detector te_sync_checker #(.LINE_W(te_sync_pkg::LINE_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .det_en (det_en),
    .hs_evt (hs_evt),
    .vs_evt (vs_evt),
    .mode   (cfg_mode),
    .line   (line_cnt),
    .match_o(match_o)
);

// File: tb/te_sync_detector_tb_top.sv
module te_sync_detector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        det_en = 1'b0;
    logic        te_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        match_o;

    int checks = 0, errors = 0;
    int cyc = 0, mcount = 0, mlast = -1, wide_pulses = 0;
    logic prev_match = 1'b0;
    int cur_mode, cur_line, cur_hs, cur_vs, cur_div;
    logic act_lvl, idle_lvl;
    int vs_end;
    int hs_end[0:31];

    te_sync_detector dut_i (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .te_in(te_in),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .match_o(match_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (match_o) begin
                mcount++;
                mlast = cyc;
                if (prev_match) wide_pulses++;
            end
            prev_match = match_o;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(bit sel, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // reconfigure with the match logic disabled, then settle the idle level
    task automatic setup(int vs, int hs, int dv, bit inv, int ln, int md);
        det_en = 1'b0;
        cur_vs = vs; cur_hs = hs; cur_div = dv; cur_line = ln; cur_mode = md;
        act_lvl = ~inv; idle_lvl = inv;
        cfg_write(1'b0, 32'(vs) | (32'(inv) << 12) | (32'(inv) << 13)
                        | (32'(ln) << 15) | (32'(md) << 26));
        cfg_write(1'b1, 32'(hs) | (32'(dv - 1) << 12));
        @(negedge clk);
        te_in = idle_lvl;
        repeat (12) @(negedge clk);
        det_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic drive_pulse(int ncyc, output int end_cyc);
        te_in = act_lvl;
        repeat (ncyc) @(negedge clk);
        te_in = idle_lvl;
        end_cyc = cyc;
        repeat (8) @(negedge clk);
    endtask

    function automatic int exp_matches(int md, int ln, int nhs);
        if (md == 3) return 1;
        if (md == 2) return (ln <= nhs) ? 1 : 0;
        return 0;
    endfunction

    task automatic run_frame(int nhs, bit glitch, string req);
        int base, e, expc, expend, dummy;
        base = mcount;
        drive_pulse((cur_vs + 2) * cur_div + 2, vs_end);
        for (int k = 1; k <= nhs; k++) begin
            if (glitch && cur_hs > 2) drive_pulse((cur_hs - 2) * cur_div, dummy);
            drive_pulse((cur_hs + 2) * cur_div + 2, e);
            hs_end[k] = e;
        end
        repeat (4) @(negedge clk);
        expc = exp_matches(cur_mode, cur_line, nhs);
        check(mcount - base == expc, req, mcount - base, expc);
        if (expc == 1) begin
            expend = (cur_mode == 3 || cur_line == 0) ? vs_end : hs_end[cur_line];
            check(mlast == expend + 3, "R10 latency", mlast, expend + 3);
        end
    endtask

    initial begin
        int base, dummy;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        check(match_o == 1'b0, "R1 match low in reset", int'(match_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(match_o == 1'b0, "R1 match low after reset", int'(match_o), 0);

        // R8: line syncs before any vertical sync are not counted
        setup(12, 4, 1, 1'b0, 1, 2);
        base = mcount;
        for (int k = 0; k < 3; k++) drive_pulse((cur_hs + 2) * cur_div + 2, dummy);
        check(mcount == base, "R8 no match before frame start", mcount - base, 0);
        run_frame(3, 1'b0, "R8 first frame after enable");

        // R2 vertical-only mode
        setup(10, 3, 1, 1'b0, 5, 3);
        run_frame(2, 1'b0, "R2 vsync mode");
        run_frame(0, 1'b0, "R2 vsync mode second frame");

        // R3 with glitch pulses, R6 target line
        setup(14, 5, 2, 1'b0, 3, 2);
        run_frame(6, 1'b1, "R3 glitches ignored, R6 line 3");
        setup(14, 5, 2, 1'b0, 0, 2);
        run_frame(4, 1'b0, "R6 target 0 on vsync");
        setup(14, 5, 1, 1'b0, 9, 2);
        run_frame(4, 1'b0, "R7 target beyond frame");
        setup(14, 5, 1, 1'b0, 2, 2);
        run_frame(6, 1'b0, "R7 one match per frame");

        // R4 divider: 26-cycle pulse is 6 ticks at div 4 (line), 25 at div 1
        setup(10, 4, 4, 1'b0, 1, 2);
        run_frame(2, 1'b0, "R4 divided ticks");

        // R5 inverted polarity
        setup(9, 3, 3, 1'b1, 2, 2);
        run_frame(5, 1'b1, "R5 inverted polarity");

        // R9 disabled
        setup(10, 3, 1, 1'b0, 0, 3);
        det_en = 1'b0;
        base = mcount;
        drive_pulse((cur_vs + 2) * cur_div + 2, dummy);
        drive_pulse((cur_hs + 2) * cur_div + 2, dummy);
        check(mcount == base, "R9 disabled no match", mcount - base, 0);

        // R11 modes 0 and 1
        setup(10, 3, 1, 1'b0, 0, 0);
        run_frame(3, 1'b0, "R11 mode 0");
        setup(10, 3, 1, 1'b0, 1, 1);
        run_frame(3, 1'b0, "R11 mode 1");

        // R12 saturated width
        setup(4095, 6, 1, 1'b0, 0, 3);
        run_frame(1, 1'b0, "R12 saturating width");

        // randomized frames
        for (int f = 0; f < 16; f++) begin
            int hs, vs, dv, md, nhs, ln;
            hs  = 3 + int'($urandom_range(5));
            vs  = hs + 4 + int'($urandom_range(4));
            if (vs < 8) vs = 8;
            dv  = 1 + int'($urandom_range(3));
            md  = 2 + int'($urandom_range(1));
            nhs = 2 + int'($urandom_range(8));
            ln  = int'($urandom_range(nhs + 2));
            setup(vs, hs, dv, 1'($urandom_range(1)), ln, md);
            run_frame(nhs, 1'($urandom_range(1)), "R6 random frame");
        end

        check(wide_pulses == 0, "R10 single-cycle pulses", wide_pulses, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule